// File: doc/BRIEF.md
# Two-Frame Serial Word Framer

This block sends one 16-bit conversion word over a single serial data line as two asynchronous character frames. Each frame holds a low start bit, eight data bits sent least significant bit first, and two high stop bits. The frame with the upper byte goes out first and the frame with the lower byte second. An external bit clock sets the bit rate. The block detects the bit clock's falling edges on its own system clock and advances the line one bit on each of them. A separate enable output marks the cycles in which the line carries a frame. Outside a frame the line rests high.

The block also makes a data-ready strobe, `ready_n_o`, with a period of `PERIOD` system-clock cycles. The strobe stays low for `PERIOD-HIGH_CYC` cycles and then high for `HIGH_CYC` cycles. At the edge where it falls again, the word held for sending is replaced by the value on `conv_word_i`. This edge is the update. The receiver starts the first frame by holding chip-select low across a bit-clock falling edge. After the first frame, one system-clock cycle of chip-select low is enough to start the second frame, as long as it comes before the next update. If chip-select stays low, both frames run back to back. While a frame is on the line, the strobe is held low so that the word cannot change under it.

The controller has five states:
- `ST_IDLE`: a fresh word is waiting.
- `ST_SEND_HI`: the upper-byte frame is on the line.
- `ST_WAIT_LO`: the second frame is pending.
- `ST_SEND_LO`: the lower-byte frame is on the line.
- `ST_SPENT`: both frames have been sent. This is also the state after reset.

The transitions are:
- start: `ST_IDLE` to `ST_SEND_HI`, on a bit-clock fall with chip-select low and the strobe low.
- chain: `ST_SEND_HI` to `ST_SEND_LO`, when the upper frame ends with chip-select low.
- park: `ST_SEND_HI` to `ST_WAIT_LO`, when the upper frame ends with chip-select high.
- resume: `ST_WAIT_LO` to `ST_SEND_LO`, when chip-select is low while the strobe is low.
- finish: `ST_SEND_LO` to `ST_SPENT`, when the lower frame ends.
- reload: any non-sending state to `ST_IDLE`, on the update.

Top module: `dual_char_framer`

## Requirements
- R1: After reset, `ready_n_o` is high, `txd_oe_o` is low, `txd_o` is high and `second_pending_o` is low. `ready_n_o` then stays high for `HIGH_CYC` (4) cycles. When no frame is active, `ready_n_o` repeats a pattern of `PERIOD-HIGH_CYC` (1020) cycles low and then `HIGH_CYC` cycles high.
- R2: A frame is 11 bit times: bit 0 is the start bit (0), bits 1 to 8 are the data byte sent least significant bit first, and bits 9 and 10 are stop bits (1). `txd_oe_o` is high for the whole frame. `txd_o` is 1 whenever `txd_oe_o` is low.
- R3: The first frame of a word carries `word[15:8]` and the second carries `word[7:0]`.
- R4: While a frame is being sent, `txd_o` changes only in the cycle after a falling edge of `bit_clk_i` is detected. With no falling edge, the line holds its value for any number of cycles.
- R5: In `ST_IDLE`, the first frame starts only on a detected falling edge of `bit_clk_i` that coincides with `cs_n_i` low while `ready_n_o` is low. A low `cs_n_i` without such an edge starts nothing.
- R6: If `cs_n_i` goes high in the middle of a frame, the frame still completes through its second stop bit. `txd_oe_o` then drops. If the finished frame was the upper one, `second_pending_o` goes high.
- R7: In `ST_WAIT_LO`, `cs_n_i` low for one system-clock cycle while `ready_n_o` is low starts the lower frame at once, with no bit-clock edge. The line shows the start bit in the next cycle.
- R8: An update clears `second_pending_o` and loads a new word. After that, the next frame sent is the upper frame of the new word.
- R9: With `cs_n_i` held low, the two frames run back to back as 22 bit times. While any frame is on the line, `ready_n_o` stays low and no update takes place, however long the frame lasts.
- R10: While `ready_n_o` is high, `cs_n_i` low (with or without a bit-clock edge) starts no frame.
- R11: In `ST_SPENT`, bit-clock falling edges with `cs_n_i` low produce no frame until the next update.
- R12: The sent word is the value `conv_word_i` had at the update edge. Later changes on `conv_word_i` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_word_i | input | 16 | Conversion word, sampled at each update |
| bit_clk_i | input | 1 | External bit clock, synchronous to `clk`; the line advances on its falling edges |
| cs_n_i | input | 1 | Active-low chip-select from the receiver |
| ready_n_o | output | 1 | Data-ready strobe; its falling edge marks an update |
| txd_o | output | 1 | Serial data line |
| txd_oe_o | output | 1 | High while a frame is driven on `txd_o` |
| second_pending_o | output | 1 | High while the lower-byte frame is waiting to be started |

## Verification
The assertions watch four things on every cycle:
- `ready_n_o` never rises while a frame is being driven.
- Every frame begins with a low start bit.
- While the line is enabled, the line holds steady unless a bit-clock fall was just detected.
- Each update leaves the block idle with nothing pending, and the pending flag only clears through a resume or an update.

The bench scenarios show the things a single-cycle property cannot:
- the exact bit order and byte order of whole frames;
- the low and high lengths of the 1024-cycle strobe;
- a frame finishing after chip-select is released, then resumed with a one-cycle pulse;
- a pending lower frame lost to an update;
- a word sampled only at its update;
- start attempts that are ignored, during the high strobe and after both frames are sent.

// File: rtl/uframe_pkg.sv
package uframe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND_HI,
        ST_WAIT_LO,
        ST_SEND_LO,
        ST_SPENT
    } fr_state_t;
endpackage

// File: rtl/uf_ready_timer.sv
// Data-ready strobe generator. Low for PERIOD-HIGH_CYC cycles, high for
// HIGH_CYC cycles; the wrap back to zero is the update. The count freezes
// one cycle short of the high phase while the framer is (or is about to be)
// driving a frame, so the word cannot be replaced under an active frame.
module uf_ready_timer #(
    parameter int PERIOD   = 1024,
    parameter int HIGH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic ready_n_o,
    output logic update_o
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] THR   = CW'(PERIOD - HIGH_CYC);
    localparam logic [CW-1:0] PRE   = CW'(PERIOD - HIGH_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= THR;
        else if (cnt == PRE && hold_i)
            cnt <= cnt;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign ready_n_o = (cnt >= THR);
    assign update_o  = (cnt == LAST);
endmodule

// File: rtl/uf_edge_det.sv
// Falling-edge detector for the external bit clock (assumed synchronous).
module uf_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    output logic fall_o
);
    logic bclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bclk_q <= 1'b0;
        else
            bclk_q <= bclk_i;
    end

    assign fall_o = bclk_q & ~bclk_i;
endmodule

// File: rtl/uf_frame_fsm.sv
// Frame sequencer: picks which byte frame is on the line and which bit of it.
module uf_frame_fsm
    import uframe_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int STOP_BITS = 2,
    localparam int FRAME_LEN = 1 + BYTE_W + STOP_BITS,
    localparam int IW        = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_i,
    input  logic          cs_n_i,
    input  logic          ready_n_i,
    input  logic          update_i,
    output fr_state_t     state_o,
    output logic [IW-1:0] idx_o,
    output logic          busy_next_o
);
    localparam logic [IW-1:0] LAST_I = IW'(FRAME_LEN - 1);

    fr_state_t     st, st_n;
    logic [IW-1:0] idx, idx_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_SPENT;
            idx <= '0;
        end else begin
            st  <= st_n;
            idx <= idx_n;
        end
    end

    always_comb begin
        st_n  = st;
        idx_n = idx;
        if (update_i) begin
            // reload: a new word replaces whatever was left unsent
            st_n  = ST_IDLE;
            idx_n = '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (fall_i && !cs_n_i && !ready_n_i) begin
                        st_n  = ST_SEND_HI;
                        idx_n = '0;
                    end
                end
                ST_SEND_HI: begin
                    if (fall_i) begin
                        if (idx == LAST_I) begin
                            idx_n = '0;
                            st_n  = cs_n_i ? ST_WAIT_LO : ST_SEND_LO;
                        end else begin
                            idx_n = idx + 1'b1;
                        end
                    end
                end
                ST_WAIT_LO: begin
                    if (!cs_n_i && !ready_n_i) begin
                        st_n  = ST_SEND_LO;
                        idx_n = '0;
                    end
                end
                ST_SEND_LO: begin
                    if (fall_i) begin
                        if (idx == LAST_I) begin
                            idx_n = '0;
                            st_n  = ST_SPENT;
                        end else begin
                            idx_n = idx + 1'b1;
                        end
                    end
                end
                ST_SPENT: begin
                    st_n = ST_SPENT;
                end
                default: begin
                    st_n  = ST_SPENT;
                    idx_n = '0;
                end
            endcase
        end
    end

    assign state_o     = st;
    assign idx_o       = idx;
    assign busy_next_o = (st_n == ST_SEND_HI) || (st_n == ST_SEND_LO);
endmodule

// File: rtl/dual_char_framer.sv
module dual_char_framer
    import uframe_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int STOP_BITS = 2,
    parameter int PERIOD    = 1024,
    parameter int HIGH_CYC  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*BYTE_W-1:0]   conv_word_i,
    input  logic                  bit_clk_i,
    input  logic                  cs_n_i,
    output logic                  ready_n_o,
    output logic                  txd_o,
    output logic                  txd_oe_o,
    output logic                  second_pending_o
);
    localparam int FRAME_LEN = 1 + BYTE_W + STOP_BITS;
    localparam int IW        = $clog2(FRAME_LEN);

    logic              fall, update, busy_next;
    fr_state_t         st;
    logic [IW-1:0]     idx;
    logic [2*BYTE_W-1:0] held;
    logic [BYTE_W-1:0] cur, shifted;
    logic              line_bit, drive;

    uf_edge_det i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_i (bit_clk_i),
        .fall_o (fall)
    );

    uf_ready_timer #(.PERIOD(PERIOD), .HIGH_CYC(HIGH_CYC)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (busy_next),
        .ready_n_o (ready_n_o),
        .update_o  (update)
    );

    uf_frame_fsm #(.BYTE_W(BYTE_W), .STOP_BITS(STOP_BITS)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_i      (fall),
        .cs_n_i      (cs_n_i),
        .ready_n_i   (ready_n_o),
        .update_i    (update),
        .state_o     (st),
        .idx_o       (idx),
        .busy_next_o (busy_next)
    );

    // Word holder: sampled only on the update edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held <= '0;
        else if (update)
            held <= conv_word_i;
    end

    // Output decode from state: byte choice, then bit within the frame.
    always_comb begin
        drive = 1'b0;
        cur   = '0;
        unique case (st)
            ST_SEND_HI: begin
                drive = 1'b1;
                cur   = held[2*BYTE_W-1:BYTE_W];
            end
            ST_SEND_LO: begin
                drive = 1'b1;
                cur   = held[BYTE_W-1:0];
            end
            default: begin
                drive = 1'b0;
                cur   = '0;
            end
        endcase
        shifted = cur >> (idx - IW'(1));
        if (idx == '0)
            line_bit = 1'b0;                 // start bit
        else if (idx <= IW'(BYTE_W))
            line_bit = shifted[0];           // data, LSB first
        else
            line_bit = 1'b1;                 // stop bits
    end

    assign txd_oe_o         = drive;
    assign txd_o            = drive ? line_bit : 1'b1;
    assign second_pending_o = (st == ST_WAIT_LO);
endmodule

// File: rtl/uf_framer_checker.sv
module uf_framer_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_clk_i,
    input logic ready_n_o,
    input logic txd_o,
    input logic txd_oe_o,
    input logic second_pending_o
);
    // R9: the strobe never goes high while a frame is driven
    assert_ready_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        txd_oe_o |-> !ready_n_o);

    // R2: every frame opens with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txd_oe_o) |-> !txd_o);

    // R4: inside a frame the line only moves after a detected bit-clock fall
    assert_line_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_oe_o && $past(txd_oe_o) && !($past(bit_clk_i, 2) && !$past(bit_clk_i)))
        |-> $stable(txd_o));

    // R8: an update leaves nothing pending and nothing on the line
    assert_update_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n_o) |-> (!second_pending_o && !txd_oe_o));

    // R7: the pending flag clears only by resuming the lower frame or by an update
    assert_pending_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(second_pending_o) |-> (txd_oe_o || $fell(ready_n_o)));
endmodule

bind dual_char_framer uf_framer_checker i_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .bit_clk_i        (bit_clk_i),
    .ready_n_o        (ready_n_o),
    .txd_o            (txd_o),
    .txd_oe_o         (txd_oe_o),
    .second_pending_o (second_pending_o)
);

// File: tb/test_dual_char_framer.sv
`timescale 1ns/1ps
module test_dual_char_framer;
    localparam int PERIOD   = 1024;
    localparam int HIGH_CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        cs_n = 1'b1;
    logic [15:0] word = 16'hA55A;
    logic        ready_n, txd, txd_oe, pending;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dual_char_framer i_dual_char_framer (
        .clk              (clk),
        .rst_n            (rst_n),
        .conv_word_i      (word),
        .bit_clk_i        (bclk),
        .cs_n_i           (cs_n),
        .ready_n_o        (ready_n),
        .txd_o            (txd),
        .txd_oe_o         (txd_oe),
        .second_pending_o (pending)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // One bit-clock period; samples the line one system cycle after the fall.
    task automatic pulse_sclk(output logic t, output logic o);
        @(negedge clk) bclk = 1'b0;
        @(negedge clk);
        t = txd;
        o = txd_oe;
        bclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_update();
        @(negedge clk);
        while (!ready_n) @(negedge clk);
        while (ready_n) @(negedge clk);
    endtask

    // Receive 11 bit times; the first may already be on the line (skip_start).
    task automatic recv_frame(input logic [7:0] b, input bit skip_start,
                              input bit release_at3, input string req);
        logic t, o;
        for (int i = 0; i < 11; i++) begin
            if (i == 0 && skip_start) begin
                t = txd;
                o = txd_oe;
            end else begin
                pulse_sclk(t, o);
            end
            chk(req, $sformatf("oe bit %0d", i), int'(o), 1);
            chk(req, $sformatf("line bit %0d", i), int'(t),
                (i == 0) ? 0 : (i <= 8) ? int'(b[i-1]) : 1);
            if (release_at3 && i == 3) cs_n = 1'b1;
        end
    endtask

    task automatic end_frame(input int exp_pend, input string req);
        logic t, o;
        pulse_sclk(t, o);
        chk(req, "oe after stop", int'(o), 0);
        chk(req, "idle line", int'(t), 1);
        chk(req, "pending", int'(pending), exp_pend);
    endtask

    task automatic t_reset();
        chk("R1", "reset ready_n", int'(ready_n), 1);
        chk("R1", "reset oe", int'(txd_oe), 0);
        chk("R1", "reset txd", int'(txd), 1);
        chk("R1", "reset pending", int'(pending), 0);
    endtask

    task automatic t_period();
        int lo, hi;
        wait_update();
        lo = 0;
        while (!ready_n) begin lo++; @(negedge clk); end
        hi = 0;
        while (ready_n) begin hi++; @(negedge clk); end
        chk("R1", "strobe low cycles", lo, PERIOD - HIGH_CYC);
        chk("R1", "strobe high cycles", hi, HIGH_CYC);
    endtask

    // Just after an update holding 16'hA55A: chip-select held low.
    task automatic t_back_to_back();
        logic t, o;
        cs_n = 1'b0;
        recv_frame(8'hA5, 0, 0, "R3 R9 upper");
        recv_frame(8'h5A, 0, 0, "R2 R9 lower");
        end_frame(0, "R9");
        chk("R9", "strobe low after 22 bits", int'(ready_n), 0);
        for (int k = 0; k < 3; k++) begin
            pulse_sclk(t, o);
            chk("R11", "no frame when spent", int'(o), 0);
        end
        cs_n = 1'b1;
    endtask

    task automatic t_release_and_resume();
        word = 16'h3C81;
        wait_update();
        word = 16'hFFFF;               // R12: must not reach the line
        cs_n = 1'b0;
        recv_frame(8'h3C, 0, 1, "R6 R12 upper");
        end_frame(1, "R6");
        repeat (5) @(negedge clk);
        chk("R7", "still pending", int'(pending), 1);
        cs_n = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        chk("R7", "resume oe", int'(txd_oe), 1);
        chk("R7", "resume start bit", int'(txd), 0);
        chk("R7", "pending cleared", int'(pending), 0);
        recv_frame(8'h81, 1, 0, "R7 R12 lower");
        end_frame(0, "R7");
    endtask

    task automatic t_stall_and_overwrite();
        logic t, o;
        bit rose, moved;
        word = 16'h96E7;
        wait_update();
        cs_n = 1'b0;
        pulse_sclk(t, o);
        chk("R5", "start on fall", int'(o), 1);
        cs_n = 1'b1;
        rose = 0; moved = 0;
        repeat (1100) begin
            @(negedge clk);
            if (ready_n) rose = 1;
            if (txd != 1'b0) moved = 1;
        end
        chk("R9", "strobe rose during frame", int'(rose), 0);
        chk("R4", "line moved without fall", int'(moved), 0);
        recv_frame(8'h96, 1, 0, "R4 upper");
        end_frame(1, "R6");
        word = 16'h4DB2;
        wait_update();
        chk("R8", "pending after update", int'(pending), 0);
        cs_n = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        chk("R5", "cs without fall", int'(txd_oe), 0);
        cs_n = 1'b0;
        recv_frame(8'h4D, 0, 1, "R8 new upper");
        end_frame(1, "R8");
    endtask

    // Pending lower frame; chip-select during the high strobe is ignored.
    task automatic t_ready_high_ignored();
        logic t, o;
        while (!ready_n) @(negedge clk);
        cs_n = 1'b0;
        pulse_sclk(t, o);
        chk("R10", "no frame while strobe high", int'(o), 0);
        chk("R10", "still pending", int'(pending), 1);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "pending dropped by update", int'(pending), 0);
        chk("R8", "strobe low after update", int'(ready_n), 0);
        chk("R10", "line idle", int'(txd_oe), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_period();
        t_back_to_back();
        t_release_and_resume();
        t_stall_and_overwrite();
        t_ready_high_ignored();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule